// File: doc/BRIEF.md
# Extended Register Write Target for a Two-Wire Serial Bus

This block is an I2C target that only accepts writes. A write carries one byte after the target address, and the block sorts that byte by its most significant bit. When that bit is clear, the byte is a command. It appears on a parallel output, together with a strobe that lasts one clock cycle. When that bit is set, the byte selects one of three 8-bit configuration registers, and the byte that follows is stored in the selected register. The three registers are alert enable, alert threshold and control. Their contents are driven continuously to neighbouring logic.

The bus lines enter as sampled open-drain inputs. The block pulls SDA low through a separate drive-low output, which an external pad or a bench resolves into the wired line. The 7-bit address the block answers to is an input pin. It does not respond to reads, general calls or 10-bit addresses, and it never stretches the clock.

Top module: `i2c_ext_reg_target`

## Requirements
- R1: A complete write of start, address with write bit 0, selector byte with bit 7 = 1, data byte and stop stores the data byte in the register the selector picks.
- R2: The target pulls SDA low during the ninth SCL pulse after each byte it accepts: a matching address byte, a selector or command byte, and an extended-register data byte.
- R3: Selector bits [1:0] choose the destination: 01 is alert enable, 10 is alert threshold, 11 is control. Selector bits [6:2] are ignored.
- R4: A byte after the address with bit 7 = 0 is acknowledged and appears on `cmd_byte_o`. `cmd_valid_o` is high for exactly one clock, and no register changes.
- R5: After reset, alert enable reads 0x04, alert threshold reads 0xFF, control reads 0x00, the command output reads 0x00 and SDA is not driven.
- R6: If the address does not match, or if the read/write bit is 1, that byte and every later byte up to the next start or stop are not acknowledged and change nothing.
- R7: A selector with bits [1:0] = 00 is acknowledged. Its data byte is also acknowledged, but it is discarded.
- R8: A repeated start or a stop that arrives before the data byte's acknowledge clock has ended leaves every register unchanged. A transaction that begins at a repeated start is processed normally.
- R9: Bytes that follow an accepted data byte or command byte in the same transaction are not acknowledged and have no effect.
- R10: SCL and SDA pass through a two-stage synchroniser. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Register, command and SDA-drive outputs update on the third rising `clk` edge after the SCL falling edge that ends the relevant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (wired value) |
| sda_low_o | output | 1 | High to pull SDA low (acknowledge) |
| target_addr_i | input | 7 | 7-bit address the block responds to |
| alert_en_o | output | 8 | Alert enable register contents |
| alert_th_o | output | 8 | Alert threshold register contents |
| control_o | output | 8 | Control register contents |
| cmd_byte_o | output | 8 | Last accepted command byte |
| cmd_valid_o | output | 1 | One-cycle strobe when a command byte is accepted |

## Verification
The hardest case to reach from the ports is a write whose selector has been accepted but whose data byte is cut off by a repeated start partway through its bits. The block must throw that partial byte away and then serve a fresh transaction correctly. The stimulus clocks four data bits, raises SDA while SCL is low, and issues a start. It then completes a full write to a different register. The bench model predicts exactly one register change, and it checks every output on every clock.

// File: rtl/i2c_xreg_pkg.sv
package i2c_xreg_pkg;

   localparam int BYTE_W    = 8;
   localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SEL,
      ST_SEL_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_SKIP
   } xfer_state_t;

   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
      logic scl_fall;
      logic sda;
   } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
   import i2c_xreg_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output bus_evt_t evt_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_chain;
   logic [SYNC_STAGES-1:0] sda_chain;
   logic                   scl_prev;
   logic                   sda_prev;
   logic                   scl_s;
   logic                   sda_s;

   // idle bus is high, so the chains reset high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_prev  <= 1'b1;
         sda_prev  <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
         sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
         scl_prev  <= scl_chain[SYNC_STAGES-1];
         sda_prev  <= sda_chain[SYNC_STAGES-1];
      end
   end

   assign scl_s = scl_chain[SYNC_STAGES-1];
   assign sda_s = sda_chain[SYNC_STAGES-1];

   always_comb begin
      evt_o.start    = scl_s & scl_prev & sda_prev & ~sda_s;
      evt_o.stop     = scl_s & scl_prev & ~sda_prev & sda_s;
      evt_o.scl_rise = scl_s & ~scl_prev;
      evt_o.scl_fall = ~scl_s & scl_prev;
      evt_o.sda      = sda_s;
   end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import i2c_xreg_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_evt_t          evt_i,
   input  logic [ADDR_W-1:0] target_addr_i,
   output logic              sda_low_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic              xreg_commit_o,
   output logic              cmd_commit_o
);

   generate
      if (ADDR_W + 1 != BYTE_W) begin : g_bad_addr
         $error("i2c_byte_engine: address plus direction bit must fill one byte");
      end
      if (SEL_W < 1 || SEL_W >= BYTE_W) begin : g_bad_sel
         $error("i2c_byte_engine: selector field width out of range");
      end
   endgenerate

   localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);

   xfer_state_t          state_q;
   logic [BYTE_W-1:0]    shreg_q;
   logic [BIT_CNT_W-1:0] cnt_q;
   logic                 drive_q;
   logic                 ext_q;
   logic [SEL_W-1:0]     sel_q;
   logic                 byte_done;
   logic                 addr_hit;
   logic                 no_cond;

   assign byte_done = (cnt_q == FULL_CNT);
   assign addr_hit  = (shreg_q[BYTE_W-1:1] == target_addr_i) && !shreg_q[0];
   assign no_cond   = !evt_i.start && !evt_i.stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         shreg_q <= '0;
         cnt_q   <= '0;
         drive_q <= 1'b0;
         ext_q   <= 1'b0;
         sel_q   <= '0;
      end else if (evt_i.start) begin
         state_q <= ST_ADDR;
         cnt_q   <= '0;
         drive_q <= 1'b0;
      end else if (evt_i.stop) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         drive_q <= 1'b0;
      end else begin
         case (state_q)
            ST_ADDR, ST_SEL, ST_DATA: begin
               if (evt_i.scl_rise && !byte_done) begin
                  shreg_q <= {shreg_q[BYTE_W-2:0], evt_i.sda};
                  cnt_q   <= cnt_q + 1'b1;
               end else if (evt_i.scl_fall && byte_done) begin
                  cnt_q <= '0;
                  if (state_q == ST_ADDR) begin
                     if (addr_hit) begin
                        state_q <= ST_ADDR_ACK;
                        drive_q <= 1'b1;
                     end else begin
                        state_q <= ST_SKIP;
                     end
                  end else if (state_q == ST_SEL) begin
                     state_q <= ST_SEL_ACK;
                     drive_q <= 1'b1;
                     ext_q   <= shreg_q[BYTE_W-1];
                     sel_q   <= shreg_q[SEL_W-1:0];
                  end else begin
                     state_q <= ST_DATA_ACK;
                     drive_q <= 1'b1;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (evt_i.scl_fall) begin
                  drive_q <= 1'b0;
                  state_q <= ST_SEL;
               end
            end
            ST_SEL_ACK: begin
               if (evt_i.scl_fall) begin
                  drive_q <= 1'b0;
                  state_q <= ext_q ? ST_DATA : ST_SKIP;
               end
            end
            ST_DATA_ACK: begin
               if (evt_i.scl_fall) begin
                  drive_q <= 1'b0;
                  state_q <= ST_SKIP;
               end
            end
            default: begin
            end
         endcase
      end
   end

   assign xreg_commit_o = (state_q == ST_DATA_ACK) && evt_i.scl_fall && no_cond;
   assign cmd_commit_o  = (state_q == ST_SEL_ACK) && !ext_q && evt_i.scl_fall && no_cond;
   assign sda_low_o     = drive_q;
   assign byte_o        = shreg_q;
   assign sel_o         = sel_q;

   // R2
   ack_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_q) |-> $past(evt_i.scl_fall));

   // R2
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_i.scl_fall && !evt_i.start && !evt_i.stop) |=> $stable(drive_q));

   // R6
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> !drive_q);

endmodule

// File: rtl/i2c_xreg_bank.sv
module i2c_xreg_bank #(
   parameter int                           NUM_REGS = 3,
   parameter int                           REG_W    = 8,
   parameter int                           SEL_W    = 2,
   parameter logic [NUM_REGS*REG_W-1:0]    RST_VEC  = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [SEL_W-1:0]          wr_sel_i,
   input  logic [REG_W-1:0]          wr_data_i,
   output logic [NUM_REGS*REG_W-1:0] regs_o
);

   generate
      if (NUM_REGS + 1 > (1 << SEL_W)) begin : g_bad_sel
         $error("i2c_xreg_bank: selector too narrow for register count");
      end
   endgenerate

   logic [NUM_REGS-1:0] hit;

   // code 0 selects nothing; register k answers to code k+1
   generate
      for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
         logic [REG_W-1:0] val_q;

         assign hit[k] = wr_en_i && (wr_sel_i == SEL_W'(k + 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q <= RST_VEC[k*REG_W +: REG_W];
            end else if (hit[k]) begin
               val_q <= wr_data_i;
            end
         end

         assign regs_o[k*REG_W +: REG_W] = val_q;
      end
   endgenerate

   // R3
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

endmodule

// File: rtl/i2c_cmd_port.sv
module i2c_cmd_port #(
   parameter int CMD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit_i,
   input  logic [CMD_W-1:0] byte_i,
   output logic [CMD_W-1:0] cmd_o,
   output logic             valid_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o   <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= commit_i;
         if (commit_i) begin
            cmd_o <= byte_i;
         end
      end
   end

   // R4
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

endmodule

// File: rtl/i2c_ext_reg_target.sv
module i2c_ext_reg_target
   import i2c_xreg_pkg::*;
#(
   parameter int          ADDR_W      = 7,
   parameter int          XREG_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  AEN_RST     = 8'h04,
   parameter logic [7:0]  ATH_RST     = 8'hFF,
   parameter logic [7:0]  CTL_RST     = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_low_o,
   input  logic [ADDR_W-1:0] target_addr_i,
   output logic [XREG_W-1:0] alert_en_o,
   output logic [XREG_W-1:0] alert_th_o,
   output logic [XREG_W-1:0] control_o,
   output logic [BYTE_W-1:0] cmd_byte_o,
   output logic              cmd_valid_o
);

   localparam int NUM_XREG = 3;
   localparam int SEL_W    = $clog2(NUM_XREG + 1);
   localparam logic [NUM_XREG*XREG_W-1:0] RST_VEC =
      {XREG_W'(CTL_RST), XREG_W'(ATH_RST), XREG_W'(AEN_RST)};

   generate
      if (XREG_W != BYTE_W) begin : g_bad_w
         $error("i2c_ext_reg_target: register width must equal the bus byte");
      end
   endgenerate

   bus_evt_t                    evt;
   logic [BYTE_W-1:0]           eng_byte;
   logic [SEL_W-1:0]            eng_sel;
   logic                        xreg_commit;
   logic                        cmd_commit;
   logic [NUM_XREG*XREG_W-1:0]  xreg_flat;

   i2c_line_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .evt_o (evt)
   );

   i2c_byte_engine #(
      .ADDR_W (ADDR_W),
      .SEL_W  (SEL_W)
   ) u_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .evt_i         (evt),
      .target_addr_i (target_addr_i),
      .sda_low_o     (sda_low_o),
      .byte_o        (eng_byte),
      .sel_o         (eng_sel),
      .xreg_commit_o (xreg_commit),
      .cmd_commit_o  (cmd_commit)
   );

   i2c_xreg_bank #(
      .NUM_REGS (NUM_XREG),
      .REG_W    (XREG_W),
      .SEL_W    (SEL_W),
      .RST_VEC  (RST_VEC)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (xreg_commit),
      .wr_sel_i  (eng_sel),
      .wr_data_i (eng_byte),
      .regs_o    (xreg_flat)
   );

   i2c_cmd_port #(
      .CMD_W (BYTE_W)
   ) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (cmd_commit),
      .byte_i   (eng_byte),
      .cmd_o    (cmd_byte_o),
      .valid_o  (cmd_valid_o)
   );

   assign alert_en_o = xreg_flat[0*XREG_W +: XREG_W];
   assign alert_th_o = xreg_flat[1*XREG_W +: XREG_W];
   assign control_o  = xreg_flat[2*XREG_W +: XREG_W];

   // R8
   xreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xreg_commit |=> $stable(xreg_flat));

   // R7
   null_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xreg_commit && eng_sel == '0) |=> $stable(xreg_flat));

   // R4
   cmd_no_xreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_commit |=> $stable(xreg_flat));

endmodule

// File: tb/tb_i2c_ext_reg_target.sv
module tb_i2c_ext_reg_target;

   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [6:0] taddr = 7'h2C;
   logic       sda_low;
   logic [7:0] aen, ath, ctl, cmd;
   logic       cmd_v;
   wire        sda_line = sda_m & ~sda_low;

   always #4 clk = ~clk;

   i2c_ext_reg_target dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_m),
      .sda_i         (sda_line),
      .sda_low_o     (sda_low),
      .target_addr_i (taddr),
      .alert_en_o    (aen),
      .alert_th_o    (ath),
      .control_o     (ctl),
      .cmd_byte_o    (cmd),
      .cmd_valid_o   (cmd_v)
   );

   // behavioural model state
   logic [7:0] exp_aen = 8'h04, exp_ath = 8'hFF, exp_ctl = 8'h00, exp_cmd = 8'h00;
   logic       exp_cv = 1'b0, exp_drv = 1'b0;
   logic       cmp_on = 1'b0;
   int         checks = 0, fails = 0;

   logic [7:0] pend_data;
   logic       pend_ack;
   int         pend_kind, pend_idx;
   string      pend_req;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R1 R10 alert_en", aen, exp_aen);
         chk("R1 R10 alert_th", ath, exp_ath);
         chk("R1 R10 control", ctl, exp_ctl);
         chk("R4 cmd_byte", cmd, exp_cmd);
         chk("R4 cmd_valid", {7'b0, cmd_v}, {7'b0, exp_cv});
         chk("R2 sda_low", {7'b0, sda_low}, {7'b0, exp_drv});
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic apply_fall(input int act);
      if (act == 1) begin
         exp_drv = pend_ack;
      end else if (act == 2) begin
         exp_drv = 1'b0;
         if (pend_ack && pend_kind == 1) begin
            exp_cmd = pend_data;
            exp_cv  = 1'b1;
         end else if (pend_ack && pend_kind == 2) begin
            case (pend_idx)
               1: exp_aen = pend_data;
               2: exp_ath = pend_data;
               3: exp_ctl = pend_data;
               default: ;
            endcase
         end
      end
   endtask

   // one SCL pulse; act 1 = byte complete, act 2 = acknowledge clock
   task automatic clock_bit(input logic b, input int act);
      sda_m = b;
      wait_n(Q);
      scl_m = 1'b1;
      wait_n(Q / 2);
      if (act == 2) chk(pend_req, {7'b0, sda_line}, {7'b0, ~pend_ack});
      wait_n(Q / 2);
      scl_m = 1'b0;
      repeat (3) @(posedge clk);
      apply_fall(act);
      @(posedge clk);
      exp_cv = 1'b0;
      @(negedge clk);
      wait_n(Q - 2);
   endtask

   task automatic send_byte(input logic [7:0] d, input logic ack, input int kind,
                            input int idx, input string req);
      pend_data = d;
      pend_ack  = ack;
      pend_kind = kind;
      pend_idx  = idx;
      pend_req  = req;
      for (int i = 7; i >= 1; i--) clock_bit(d[i], 0);
      clock_bit(d[0], 1);
      clock_bit(1'b1, 2);
   endtask

   task automatic send_partial(input logic [7:0] d, input int n);
      for (int i = 7; i >= 8 - n; i--) clock_bit(d[i], 0);
   endtask

   task automatic start_c();
      sda_m = 1'b1;
      wait_n(Q);
      scl_m = 1'b1;
      wait_n(Q);
      sda_m = 1'b0;
      wait_n(Q);
      scl_m = 1'b0;
      wait_n(Q);
   endtask

   task automatic stop_c();
      sda_m = 1'b0;
      wait_n(Q);
      scl_m = 1'b1;
      wait_n(Q);
      sda_m = 1'b1;
      wait_n(Q);
   endtask

   task automatic addr_w();
      send_byte({taddr, 1'b0}, 1'b1, 0, 0, "R2 address ack");
   endtask

   task automatic ext_write(input logic [7:0] sel, input logic [7:0] d, input string req);
      start_c();
      addr_w();
      send_byte(sel, 1'b1, 0, 0, {req, " R2 selector ack"});
      send_byte(d, 1'b1, 2, int'(sel[1:0]), {req, " R2 data ack"});
      stop_c();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      cmp_on = 1'b1;
      // R5 reset values
      chk("R5 alert_en reset", aen, 8'h04);
      chk("R5 alert_th reset", ath, 8'hFF);
      chk("R5 control reset", ctl, 8'h00);
      chk("R5 cmd reset", cmd, 8'h00);
      chk("R5 sda released", {7'b0, sda_low}, 8'h00);
      wait_n(3);
      rst_n = 1'b1;
      wait_n(10);

      // R1 R3 plain extended writes to each register
      ext_write(8'h82, 8'h5A, "R1");
      chk("R1 alert_th written", ath, 8'h5A);
      ext_write(8'h81, 8'h13, "R3");
      chk("R3 alert_en written", aen, 8'h13);
      ext_write(8'h83, 8'h01, "R3");
      chk("R3 control written", ctl, 8'h01);
      // R3 middle selector bits ignored
      ext_write(8'hFD, 8'h3C, "R3");
      chk("R3 bits 6:2 ignored", aen, 8'h3C);

      // R4 command byte, then R9 trailing byte ignored
      start_c();
      addr_w();
      send_byte(8'h35, 1'b1, 1, 0, "R4 command ack");
      send_byte(8'hC2, 1'b0, 0, 0, "R9 byte after command");
      stop_c();
      chk("R4 command value", cmd, 8'h35);
      chk("R4 alert_th untouched", ath, 8'h5A);

      // R6 wrong address
      start_c();
      send_byte({taddr ^ 7'h01, 1'b0}, 1'b0, 0, 0, "R6 foreign address");
      send_byte(8'h82, 1'b0, 0, 0, "R6 ignored selector");
      send_byte(8'h00, 1'b0, 0, 0, "R6 ignored data");
      stop_c();
      chk("R6 alert_th kept", ath, 8'h5A);
      // R6 read direction bit
      start_c();
      send_byte({taddr, 1'b1}, 1'b0, 0, 0, "R6 read request");
      send_byte(8'h83, 1'b0, 0, 0, "R6 ignored after read");
      stop_c();
      chk("R6 control kept", ctl, 8'h01);

      // R7 null selector
      ext_write(8'h80, 8'hAA, "R7");
      chk("R7 alert_en kept", aen, 8'h3C);
      chk("R7 alert_th kept", ath, 8'h5A);
      chk("R7 control kept", ctl, 8'h01);

      // R8 repeated start in the middle of a data byte
      start_c();
      addr_w();
      send_byte(8'h82, 1'b1, 0, 0, "R8 selector ack");
      send_partial(8'h11, 4);
      start_c();
      addr_w();
      send_byte(8'h83, 1'b1, 0, 0, "R8 second selector ack");
      send_byte(8'h02, 1'b1, 2, 3, "R8 second data ack");
      stop_c();
      chk("R8 aborted write discarded", ath, 8'h5A);
      chk("R8 follow-up write applied", ctl, 8'h02);

      // R8 stop right after the selector
      start_c();
      addr_w();
      send_byte(8'h81, 1'b1, 0, 0, "R8 selector before stop");
      stop_c();
      chk("R8 stop leaves alert_en", aen, 8'h3C);

      // R9 extra byte after an accepted data byte
      start_c();
      addr_w();
      send_byte(8'h83, 1'b1, 0, 0, "R9 selector ack");
      send_byte(8'h07, 1'b1, 2, 3, "R9 data ack");
      send_byte(8'hFF, 1'b0, 0, 0, "R9 trailing byte");
      stop_c();
      chk("R9 control holds first data", ctl, 8'h07);

      // R10 idle with SCL high and SDA moving only via start/stop
      wait_n(20);
      chk("R10 idle line released", {7'b0, sda_low}, 8'h00);

      cmp_on = 1'b0;
      summary();
      $finish;
   end

endmodule